// File: doc/BRIEF.md
# Stop-Mode Wake-Up Sequencer

This block steers the clock subsystem of a small controller into a deep stop state and back out again. In the stop state only the internal RC oscillator keeps running. The main oscillator enable and the CPU clock enable are dropped, and the block waits for a wake source. A wake source is either an external interrupt line, which is asynchronous and is synchronized here, or a watchdog timeout.

After a wake source arrives, the main oscillator is re-enabled. An 8-bit settling counter then runs from zero to its top value on a prescaled tick. The CPU clock stays gated until that counter overflows. In the cycle the clock returns, the block raises a one-cycle pulse on exactly one of three outputs. The pulse tells the core to take the watchdog interrupt vector, to perform an internal reset, or to continue at the instruction after the stop.

The choice among the three outcomes depends on the wake cause, the global interrupt-enable flag and the two watchdog configuration bits. A hardware reset returns the sequencer to its idle state from anywhere.

Top module: `lpwr_wake_ctrl`

## Requirements
- R1: The status output encodes idle as 0, stopped as 1, settling as 2 and the outcome cycle as 3. From idle, a stop request moves to stopped on the next clock only when `mode_sel` equals binary 01. A stop request with any other `mode_sel` value leaves the status at idle.
- R2: While stopped, `main_osc_en` and `cpu_clk_en` are 0 and `rc_osc_en` is 1.
- R3: The stopped state holds until a wake source appears. A wake source is `wdt_timeout` sampled high, or `ext_irq` after its two-flop synchronizer, which is seen on the third rising edge after it goes high. When both are present together, the watchdog is taken as the cause.
- R4: On leaving the stopped state, the status becomes settling and the settling count starts at 0. The count climbs by one per tick up to 255. The tick that finds 255 ends settling. `cpu_clk_en` stays 0 while settling and `main_osc_en` is 1.
- R5: The tick occurs once every 2^`div_sel` clocks. Settling therefore lasts exactly 256 × 2^`div_sel` clocks, counted from the edge that enters settling to the edge that enters the outcome state.
- R6: A watchdog wake with `irq_enable`=1 and `wdt_rst_en`=1 yields a pulse on `int_reset`.
- R7: A watchdog wake with `irq_enable`=1, `wdt_rst_en`=0 and `wdt_irq_en`=1 yields a pulse on `vector_wdt`.
- R8: Every other case yields a pulse on `resume_next`. This covers any wake with `irq_enable`=0, an external-interrupt wake, and a watchdog wake with both watchdog enables at 0.
- R9: Exactly one outcome pulse is high, for exactly the one cycle in which the status reads 3. The next cycle returns to idle with all three clock enables at 1. No outcome output is high in any other state.
- R10: Driving `rst_n` low returns the status to idle at once from any state, with the settling count at 0, all outcome outputs at 0 and all clock enables at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RC-domain clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| stop_req | input | 1 | Stop request from the CPU |
| mode_sel | input | 2 | Low-power mode select; 01 selects RC stop |
| irq_enable | input | 1 | Global interrupt-enable flag |
| wdt_rst_en | input | 1 | Watchdog wake causes reset when 1 |
| wdt_irq_en | input | 1 | Watchdog interrupt enable |
| ext_irq | input | 1 | Asynchronous external interrupt |
| wdt_timeout | input | 1 | Watchdog timeout event |
| div_sel | input | DIV_SEL_W | Tick divide ratio exponent |
| main_osc_en | output | 1 | Main oscillator enable |
| rc_osc_en | output | 1 | RC oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| vector_wdt | output | 1 | Pulse: take watchdog interrupt vector |
| int_reset | output | 1 | Pulse: perform internal reset |
| resume_next | output | 1 | Pulse: resume after stop |
| state_o | output | 2 | Sequencer status |
| stab_count_o | output | STAB_W | Settling counter value |

## Verification
The bench uses the default widths: an 8-bit settling counter and a 2-bit divide select. With these, every ratio from 1 to 8 can be exercised, and the longest settling period is 2048 clocks. This lets the exact settling length be measured for every `div_sel` value, along with every combination of cause, interrupt flag and watchdog enables, within a short run. The bench also covers the synchronizer delay on the external line, rejected mode codes, and a reset that arrives while settling.

// File: rtl/lpwr_wake_pkg.sv
package lpwr_wake_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_STOPPED   = 2'd1,
        ST_STABILIZE = 2'd2,
        ST_RUN       = 2'd3
    } wake_state_e;

    localparam logic [1:0] MODE_RC_STOP = 2'b01;

    typedef struct packed {
        wake_state_e state;
        logic        cause_wdt;
        logic        vec;
        logic        rst;
        logic        res;
    } wake_regs_t;

endpackage

// File: rtl/lpwr_sync.sv
module lpwr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/lpwr_stab_timer.sv
module lpwr_stab_timer #(
    parameter int STAB_W    = 8,
    parameter int DIV_SEL_W = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear_i,
    input  logic                 run_i,
    input  logic [DIV_SEL_W-1:0] div_sel_i,
    output logic [STAB_W-1:0]    count_o,
    output logic                 done_o
);
    localparam int PRE_W = (1 << DIV_SEL_W) - 1;
    localparam logic [STAB_W-1:0] TOP = '1;

    typedef struct packed {
        logic [PRE_W-1:0]  pre;
        logic [STAB_W-1:0] cnt;
    } timer_regs_t;

    timer_regs_t      t_d, t_q;
    logic [PRE_W-1:0] mask;
    logic             tick;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < int'(div_sel_i));
        end
    end

    assign tick   = run_i && ((t_q.pre & mask) == mask);
    assign done_o = tick && (t_q.cnt == TOP);

    always_comb begin
        t_d = t_q;
        if (clear_i) begin
            t_d.pre = '0;
            t_d.cnt = '0;
        end else if (run_i) begin
            t_d.pre = t_q.pre + PRE_W'(1);
            if (tick && !done_o) t_d.cnt = t_q.cnt + STAB_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign count_o = t_q.cnt;
endmodule

// File: rtl/lpwr_outcome.sv
module lpwr_outcome (
    input  logic cause_wdt_i,
    input  logic irq_enable_i,
    input  logic wdt_rst_en_i,
    input  logic wdt_irq_en_i,
    output logic vec_o,
    output logic rst_o,
    output logic res_o
);
    always_comb begin
        vec_o = 1'b0;
        rst_o = 1'b0;
        res_o = 1'b0;
        if (cause_wdt_i && irq_enable_i && wdt_rst_en_i)      rst_o = 1'b1;
        else if (cause_wdt_i && irq_enable_i && wdt_irq_en_i) vec_o = 1'b1;
        else                                                  res_o = 1'b1;
    end
endmodule

// File: rtl/lpwr_wake_ctrl.sv
module lpwr_wake_ctrl
    import lpwr_wake_pkg::*;
#(
    parameter int STAB_W    = 8,
    parameter int DIV_SEL_W = 2,
    parameter int SYNC_STG  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stop_req,
    input  logic [1:0]           mode_sel,
    input  logic                 irq_enable,
    input  logic                 wdt_rst_en,
    input  logic                 wdt_irq_en,
    input  logic                 ext_irq,
    input  logic                 wdt_timeout,
    input  logic [DIV_SEL_W-1:0] div_sel,
    output logic                 main_osc_en,
    output logic                 rc_osc_en,
    output logic                 cpu_clk_en,
    output logic                 vector_wdt,
    output logic                 int_reset,
    output logic                 resume_next,
    output logic [1:0]           state_o,
    output logic [STAB_W-1:0]    stab_count_o
);
    wake_regs_t r_d, r_q;
    logic       ext_sync;
    logic       stab_done;
    logic       oc_vec, oc_rst, oc_res;
    logic       wake_cause_wdt;

    lpwr_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_irq),
        .sync_o  (ext_sync)
    );

    lpwr_stab_timer #(.STAB_W(STAB_W), .DIV_SEL_W(DIV_SEL_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (r_q.state != ST_STABILIZE),
        .run_i     (r_q.state == ST_STABILIZE),
        .div_sel_i (div_sel),
        .count_o   (stab_count_o),
        .done_o    (stab_done)
    );

    lpwr_outcome u_outcome (
        .cause_wdt_i  (r_q.cause_wdt),
        .irq_enable_i (irq_enable),
        .wdt_rst_en_i (wdt_rst_en),
        .wdt_irq_en_i (wdt_irq_en),
        .vec_o        (oc_vec),
        .rst_o        (oc_rst),
        .res_o        (oc_res)
    );

    assign wake_cause_wdt = wdt_timeout;

    always_comb begin
        r_d     = r_q;
        r_d.vec = 1'b0;
        r_d.rst = 1'b0;
        r_d.res = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (stop_req && (mode_sel == MODE_RC_STOP)) r_d.state = ST_STOPPED;
            end
            ST_STOPPED: begin
                if (wdt_timeout || ext_sync) begin
                    r_d.state     = ST_STABILIZE;
                    r_d.cause_wdt = wake_cause_wdt;
                end
            end
            ST_STABILIZE: begin
                if (stab_done) begin
                    r_d.state = ST_RUN;
                    r_d.vec   = oc_vec;
                    r_d.rst   = oc_rst;
                    r_d.res   = oc_res;
                end
            end
            ST_RUN: begin
                r_d.state     = ST_IDLE;
                r_d.cause_wdt = 1'b0;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, cause_wdt: 1'b0, vec: 1'b0, rst: 1'b0, res: 1'b0};
        else        r_q <= r_d;
    end

    assign main_osc_en = (r_q.state != ST_STOPPED);
    assign rc_osc_en   = 1'b1;
    assign cpu_clk_en  = (r_q.state == ST_IDLE) || (r_q.state == ST_RUN);
    assign vector_wdt  = r_q.vec;
    assign int_reset   = r_q.rst;
    assign resume_next = r_q.res;
    assign state_o     = r_q.state;
endmodule

// File: rtl/lpwr_wake_chk.sv
module lpwr_wake_chk #(
    parameter int STAB_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_req,
    input logic [1:0]        mode_sel,
    input logic              main_osc_en,
    input logic              rc_osc_en,
    input logic              cpu_clk_en,
    input logic              vector_wdt,
    input logic              int_reset,
    input logic              resume_next,
    input logic [1:0]        state_o,
    input logic [STAB_W-1:0] stab_count_o
);
    // R1: correct mode code enters stop
    p_enter_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && stop_req && mode_sel == 2'b01) |=> state_o == 2'd1);

    // R1: other mode codes are ignored
    p_reject_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && !(stop_req && mode_sel == 2'b01)) |=> state_o == 2'd0);

    // R2: clocking while stopped
    p_stop_clk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1) |-> (!main_osc_en && rc_osc_en && !cpu_clk_en));

    // R4: settling starts from zero
    p_stab_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2 && $past(state_o) == 2'd1) |-> stab_count_o == '0);

    // R4: CPU clock gated while settling
    p_stab_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd2) |-> (main_osc_en && !cpu_clk_en));

    // R4: outcome only after full count
    p_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3) |-> ($past(state_o) == 2'd2 && $past(stab_count_o) == '1));

    // R9: one pulse, only in outcome state, then idle
    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({vector_wdt, int_reset, resume_next}));
    p_pulse_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3) == ($countones({vector_wdt, int_reset, resume_next}) == 1));
    p_return_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd3) |=> (state_o == 2'd0 && cpu_clk_en));
endmodule

bind lpwr_wake_ctrl lpwr_wake_chk #(.STAB_W(STAB_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_req     (stop_req),
    .mode_sel     (mode_sel),
    .main_osc_en  (main_osc_en),
    .rc_osc_en    (rc_osc_en),
    .cpu_clk_en   (cpu_clk_en),
    .vector_wdt   (vector_wdt),
    .int_reset    (int_reset),
    .resume_next  (resume_next),
    .state_o      (state_o),
    .stab_count_o (stab_count_o)
);

// File: tb/lpwr_wake_ctrl_tb.sv
module lpwr_wake_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int STAB_W     = 8;
    localparam int DIV_SEL_W  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stop_req = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic irq_enable = 1'b0, wdt_rst_en = 1'b0, wdt_irq_en = 1'b0;
    logic ext_irq = 1'b0, wdt_timeout = 1'b0;
    logic [DIV_SEL_W-1:0] div_sel = '0;
    logic main_osc_en, rc_osc_en, cpu_clk_en;
    logic vector_wdt, int_reset, resume_next;
    logic [1:0] state_o;
    logic [STAB_W-1:0] stab_count_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lpwr_wake_ctrl #(.STAB_W(STAB_W), .DIV_SEL_W(DIV_SEL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .mode_sel(mode_sel),
        .irq_enable(irq_enable), .wdt_rst_en(wdt_rst_en), .wdt_irq_en(wdt_irq_en),
        .ext_irq(ext_irq), .wdt_timeout(wdt_timeout), .div_sel(div_sel),
        .main_osc_en(main_osc_en), .rc_osc_en(rc_osc_en), .cpu_clk_en(cpu_clk_en),
        .vector_wdt(vector_wdt), .int_reset(int_reset), .resume_next(resume_next),
        .state_o(state_o), .stab_count_o(stab_count_o)
    );

    function automatic logic [2:0] exp_outcome(bit wdt, bit ien, bit ren, bit wen);
        // {vector_wdt, int_reset, resume_next}
        if (wdt && ien && ren) return 3'b010;
        if (wdt && ien && wen) return 3'b100;
        return 3'b001;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic summary_and_end();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            summary_and_end();
        end
    end

    task automatic trial(logic [1:0] mode, bit wdt, bit both, bit ien, bit ren, bit wen,
                         logic [DIV_SEL_W-1:0] sel);
        int n;
        int gate_bad;
        logic [2:0] e;
        irq_enable = ien; wdt_rst_en = ren; wdt_irq_en = wen; div_sel = sel;
        stop_req = 1'b1; mode_sel = mode;
        step();
        stop_req = 1'b0;
        if (mode != 2'b01) begin
            check(state_o == 2'd0, "R1 ignored mode", state_o, 0);
            return;
        end
        check(state_o == 2'd1, "R1 enter stop", state_o, 1);
        check(!main_osc_en && rc_osc_en && !cpu_clk_en, "R2 stop clocks",
              {main_osc_en, rc_osc_en, cpu_clk_en}, 3'b010);
        step(4);
        check(state_o == 2'd1, "R3 hold without wake", state_o, 1);
        if (wdt) begin
            wdt_timeout = 1'b1;
            if (both) ext_irq = 1'b1;
            step();
            wdt_timeout = 1'b0;
            ext_irq = 1'b0;
        end else begin
            ext_irq = 1'b1;
            step(2);
            check(state_o == 2'd1, "R3 sync delay", state_o, 1);
            step();
            ext_irq = 1'b0;
        end
        check(state_o == 2'd2 && stab_count_o == 0, "R4 settle start",
              {state_o, stab_count_o}, {2'd2, 8'd0});
        n = 0;
        gate_bad = 0;
        while (state_o == 2'd2 && n < 5000) begin
            if (cpu_clk_en || !main_osc_en) gate_bad++;
            step();
            n++;
        end
        check(gate_bad == 0, "R4 gated while settling", gate_bad, 0);
        check(n == (256 << sel), "R5 settle length", n, 256 << sel);
        e = exp_outcome(wdt, ien, ren, wen);
        check(state_o == 2'd3 && {vector_wdt, int_reset, resume_next} == e,
              e[1] ? "R6 reset outcome" : (e[2] ? "R7 vector outcome" : "R8 resume outcome"),
              {vector_wdt, int_reset, resume_next}, e);
        step();
        check(state_o == 2'd0 && {vector_wdt, int_reset, resume_next} == 3'b000 &&
              cpu_clk_en && main_osc_en, "R9 single pulse then idle",
              {state_o, vector_wdt, int_reset, resume_next}, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        step(3);
        check(state_o == 2'd0 && cpu_clk_en && main_osc_en && rc_osc_en &&
              {vector_wdt, int_reset, resume_next} == 3'b000, "R10 reset state", state_o, 0);
        rst_n = 1'b1;
        step(2);

        // directed corners
        trial(2'b00, 1, 0, 1, 1, 0, 0);
        trial(2'b11, 1, 0, 1, 1, 0, 0);
        trial(2'b01, 1, 0, 1, 1, 0, 0);   // R6
        trial(2'b01, 1, 0, 1, 0, 1, 1);   // R7
        trial(2'b01, 1, 0, 0, 1, 1, 2);   // R8, flag clear
        trial(2'b01, 0, 0, 1, 1, 1, 3);   // R8, external wake
        trial(2'b01, 1, 0, 1, 0, 0, 0);   // R8, both watchdog enables off
        trial(2'b01, 1, 1, 1, 1, 0, 0);   // R3, watchdog wins over external

        // reset while settling (R10)
        irq_enable = 1'b1; div_sel = 2'd1;
        stop_req = 1'b1; mode_sel = 2'b01;
        step();
        stop_req = 1'b0;
        wdt_timeout = 1'b1;
        step();
        wdt_timeout = 1'b0;
        step(20);
        rst_n = 1'b0;
        #1;
        check(state_o == 2'd0 && stab_count_o == 0 && cpu_clk_en && main_osc_en,
              "R10 async reset", {state_o, stab_count_o}, 0);
        step(2);
        rst_n = 1'b1;
        step(2);

        // constrained random
        for (int k = 0; k < 14; k++) begin
            logic [1:0] m;
            m = ($urandom % 4 == 0) ? 2'($urandom) : 2'b01;
            trial(m, 1'($urandom), 1'b0, 1'($urandom), 1'($urandom), 1'($urandom),
                  DIV_SEL_W'($urandom % 3));
            step(1 + ($urandom % 3));
        end

        done = 1'b1;
        summary_and_end();
    end
endmodule